// File: doc/BRIEF.md
# Programmable Galois LFSR Generator

This block is an N-bit linear feedback shift register in the internal-XOR (Galois) arrangement. Each stage passes its value to the stage above it. Stage 0 receives the top stage's output. Every intermediate stage whose feedback coefficient is set also folds the top stage's output into the value it receives. The coefficients for stages 1 to N-1 are held in a register that is loaded at run time, so one instance can walk through different state sequences. The end coefficients are implicitly 1 and are not stored.

The seed strobe sets the starting state. A sense select chooses XOR or XNOR feedback. The block flags the state that cannot be escaped in the current sense: all zeros for XOR and all ones for XNOR. It also emits a one-cycle pulse each time an enabled step returns the register to the seed most recently loaded. Typical uses are test pattern generation, scrambling and counting with a long period.

Top module: `galois_lfsr_gen`

## Requirements
- R1: After a synchronous active-low reset, `state` is all ones if `mode_xnor` is 0 and all zeros if `mode_xnor` is 1. The coefficient register takes the value of parameter `COEF_RESET`. `period_done` is 0.
- R2: In XOR mode (`mode_xnor`=0), each enabled step makes stage 0 take stage N-1. Each stage i from 1 to N-1 takes stage i-1 XOR (g_i AND stage N-1), where g_i is `coef_val[i]`.
- R3: For N=3 with g1=1 and g2=0, the seed 3'b111 steps to 3'b101 and then to 3'b001. The cycle holds 7 distinct states and never contains 3'b000.
- R4: In XNOR mode (`mode_xnor`=1), stage 0 still takes stage N-1, and each stage with g_i=1 takes stage i-1 XNOR stage N-1. Next(s) therefore equals the bitwise complement of the XOR-mode next state of the complement of s.
- R5: When `step_en` is 0 and no seed is loaded, `state` holds its value.
- R6: When `seed_ld` is 1, `state` equals `seed_val` after that clock, whether or not `step_en` is set. Stepping is suppressed in that cycle.
- R7: `lock_up` is 1 combinationally whenever `state` equals the forbidden pattern of the current mode (all zeros for XOR, all ones for XNOR). A forbidden seed is accepted and flagged, and later steps leave it unchanged.
- R8: `period_done` is 1 for the cycle after an enabled step whose result equals the last loaded seed. It is 0 after a seed-load clock and 0 after every other step.
- R9: A coefficient load changes the coefficients on the next clock and leaves `state` unchanged. A step taken in the same clock as the load still uses the old coefficients.
- R10: With the default coefficients (g4=g5=g6=1, for N=8), starting from a nonzero seed, the sequence returns to the seed after exactly 255 steps and never reaches all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| step_en | input | 1 | Advance the register by one step |
| seed_ld | input | 1 | Load `seed_val` into the state; overrides stepping |
| seed_val | input | WIDTH | Seed value |
| coef_ld | input | 1 | Load `coef_val` into the coefficient register |
| coef_val | input | WIDTH-1 ([WIDTH-1:1]) | Feedback coefficients; bit i is g_i |
| mode_xnor | input | 1 | 0 selects XOR feedback, 1 selects XNOR feedback |
| state | output | WIDTH | Current register contents |
| period_done | output | 1 | One-cycle pulse when a step lands on the loaded seed |
| lock_up | output | 1 | Current state is the forbidden pattern for the mode |

## Verification
`state`, `period_done` and the coefficient register each sit one register behind their stimulus. For a seed load, a step or a coefficient load, the result is therefore visible after the next rising edge. `lock_up` is a combinational decode of `state` and `mode_xnor`, so it is valid within the same cycle. The bench drives every input just after a rising edge and samples one time unit after the following edge, so each check reads the value that edge produced. A coefficient load is checked over two edges: at the first the state follows the old taps, and at the second it follows the new ones.

// File: rtl/lfsr_pkg.sv
// Package: shared definitions for the programmable Galois LFSR.
// Assumes: nothing beyond IEEE 1800-2017.
package lfsr_pkg;

    // Feedback sense of the register.
    typedef enum logic {
        FB_XOR  = 1'b0,
        FB_XNOR = 1'b1
    } fb_sense_e;

endpackage

// File: rtl/lfsr_next_state.sv
// Module: lfsr_next_state
// Computes the Galois next state from the present state, the coefficient
// vector g[W-1:1] and the feedback sense. Purely combinational.
// Assumes: W >= 2; the end coefficients are implicitly 1.
module lfsr_next_state
    import lfsr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] cur_i,
    input  logic [W-1:1] taps_i,
    input  fb_sense_e    sense_i,
    output logic [W-1:0] nxt_o
);

    localparam int TOP = W - 1;

    logic fb_bit;
    assign fb_bit = cur_i[TOP];

    // Stage 0 always takes the top stage.
    assign nxt_o[0] = fb_bit;

    // Stages 1..W-1: plain shift, or a shift mixed with feedback.
    for (genvar gi = 1; gi < W; gi++) begin : g_stage
        logic mixed;
        assign mixed = (sense_i == FB_XNOR) ? ~(cur_i[gi-1] ^ fb_bit)
                                            :  (cur_i[gi-1] ^ fb_bit);
        assign nxt_o[gi] = taps_i[gi] ? mixed : cur_i[gi-1];
    end

endmodule

// File: rtl/lfsr_coef_reg.sv
// Module: lfsr_coef_reg
// Holds the runtime feedback coefficients g[W-1:1]. A load takes effect on
// the clock edge that samples it.
// Assumes: synchronous active-low reset to RST_VAL.
module lfsr_coef_reg #(
    parameter int           W       = 8,
    parameter logic [W-1:1] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:1] din_i,
    output logic [W-1:1] taps_o
);

    logic [W-1:1] taps_q;

    // Capture the coefficient vector on a load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taps_q <= RST_VAL;
        end else if (load_i) begin
            taps_q <= din_i;
        end
    end

    assign taps_o = taps_q;

    AST_COEF_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (taps_q == $past(din_i)));                  // R9
    AST_COEF_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(taps_q));                          // R9

endmodule

// File: rtl/lfsr_period_mon.sv
// Module: lfsr_period_mon
// Remembers the last loaded seed and raises a one-cycle flag for the cycle
// after an enabled step whose result equals that seed.
// Assumes: step_i is already suppressed by the caller during seed loads.
module lfsr_period_mon #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rst_seed_i,
    input  logic         seed_ld_i,
    input  logic [W-1:0] seed_i,
    input  logic         step_i,
    input  logic [W-1:0] nxt_i,
    input  logic [W-1:0] cur_i,
    output logic         done_o
);

    logic [W-1:0] seed_q;
    logic         done_q;

    // Track the seed of the current run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seed_q <= rst_seed_i;
        end else if (seed_ld_i) begin
            seed_q <= seed_i;
        end
    end

    // Flag a step that lands back on the seed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= step_i && !seed_ld_i && (nxt_i == seed_q);
        end
    end

    assign done_o = done_q;

    AST_DONE_AT_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (cur_i == seed_q));                         // R8
    AST_NO_DONE_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        seed_ld_i |=> !done_q);                                // R8

endmodule

// File: rtl/galois_lfsr_gen.sv
// Module: galois_lfsr_gen (top)
// Programmable N-bit Galois LFSR: runtime coefficients, XOR/XNOR sense,
// seed load with priority over stepping, lock-up and period-complete flags.
// Assumes: WIDTH >= 2; synchronous active-low reset; COEF_RESET bit i is g_i.
module galois_lfsr_gen
    import lfsr_pkg::*;
#(
    parameter int               WIDTH      = 8,
    parameter logic [WIDTH-1:1] COEF_RESET = 'h38
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic             seed_ld,
    input  logic [WIDTH-1:0] seed_val,
    input  logic             coef_ld,
    input  logic [WIDTH-1:1] coef_val,
    input  logic             mode_xnor,
    output logic [WIDTH-1:0] state,
    output logic             period_done,
    output logic             lock_up
);

    localparam logic [WIDTH-1:0] ALL_ONES  = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ALL_ZEROS = {WIDTH{1'b0}};

    fb_sense_e        sense;
    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] nxt;
    logic [WIDTH-1:1] taps;
    logic [WIDTH-1:0] rst_pattern;
    logic [WIDTH-1:0] bad_pattern;
    logic             step_go;

    assign sense       = mode_xnor ? FB_XNOR : FB_XOR;
    assign rst_pattern = mode_xnor ? ALL_ZEROS : ALL_ONES;
    assign bad_pattern = mode_xnor ? ALL_ONES  : ALL_ZEROS;
    assign step_go     = step_en && !seed_ld;

    lfsr_coef_reg #(
        .W       (WIDTH),
        .RST_VAL (COEF_RESET)
    ) u_coef (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (coef_ld),
        .din_i  (coef_val),
        .taps_o (taps)
    );

    lfsr_next_state #(
        .W (WIDTH)
    ) u_next (
        .cur_i   (state_q),
        .taps_i  (taps),
        .sense_i (sense),
        .nxt_o   (nxt)
    );

    // State register: reset, then seed load, then step, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= rst_pattern;
        end else if (seed_ld) begin
            state_q <= seed_val;
        end else if (step_en) begin
            state_q <= nxt;
        end
    end

    lfsr_period_mon #(
        .W (WIDTH)
    ) u_period (
        .clk        (clk),
        .rst_n      (rst_n),
        .rst_seed_i (rst_pattern),
        .seed_ld_i  (seed_ld),
        .seed_i     (seed_val),
        .step_i     (step_go),
        .nxt_i      (nxt),
        .cur_i      (state_q),
        .done_o     (period_done)
    );

    assign state   = state_q;
    assign lock_up = (state_q == bad_pattern);

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !seed_ld) |=> $stable(state_q));          // R5
    AST_SEED_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        seed_ld |=> (state_q == $past(seed_val)));             // R6
    AST_LOCK_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_up && step_en && !seed_ld) |=> $stable(state_q)); // R7

endmodule

// File: tb/galois_lfsr_gen_tb.sv
module galois_lfsr_gen_tb;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         step_en, seed_ld, coef_ld, mode_xnor;
    logic [W-1:0] seed_val;
    logic [W-1:1] coef_val;
    logic [W-1:0] state;
    logic         period_done, lock_up;

    logic         s_step, s_seed_ld, s_coef_ld;
    logic [2:0]   s_seed;
    logic [2:1]   s_coef;
    logic [2:0]   s_state;
    logic         s_done, s_lock;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    galois_lfsr_gen #(.WIDTH(W), .COEF_RESET(7'h38)) u_dut (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .seed_ld(seed_ld),
        .seed_val(seed_val), .coef_ld(coef_ld), .coef_val(coef_val),
        .mode_xnor(mode_xnor), .state(state), .period_done(period_done),
        .lock_up(lock_up));

    galois_lfsr_gen #(.WIDTH(3), .COEF_RESET(2'b11)) u_dut_w3 (
        .clk(clk), .rst_n(rst_n), .step_en(s_step), .seed_ld(s_seed_ld),
        .seed_val(s_seed), .coef_ld(s_coef_ld), .coef_val(s_coef),
        .mode_xnor(1'b0), .state(s_state), .period_done(s_done),
        .lock_up(s_lock));

    // Bench model of the XOR-mode step (R2).
    function automatic logic [W-1:0] m_xor(logic [W-1:0] s, logic [W-1:1] g);
        logic [W-1:0] n;
        n[0] = s[W-1];
        for (int i = 1; i < W; i++) n[i] = s[i-1] ^ (g[i] & s[W-1]);
        return n;
    endfunction

    // Bench model of the XNOR-mode step (R4).
    function automatic logic [W-1:0] m_xnor(logic [W-1:0] s, logic [W-1:1] g);
        return ~m_xor(~s, g);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Advance one edge and sample just after it.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        step_en = 0; seed_ld = 0; coef_ld = 0;
        s_step = 0; s_seed_ld = 0; s_coef_ld = 0;
    endtask

    task automatic do_reset(input logic xn);
        idle_inputs();
        mode_xnor = xn;
        rst_n = 0;
        tick(); tick();
        rst_n = 1;
    endtask

    task automatic load_seed(input logic [W-1:0] v);
        seed_val = v; seed_ld = 1; step_en = 1;
        tick();
        seed_ld = 0; step_en = 0;
    endtask

    task automatic load_coef(input logic [W-1:1] g);
        coef_val = g; coef_ld = 1;
        tick();
        coef_ld = 0;
    endtask

    task automatic t_reset();
        do_reset(1'b0);
        chk(state == 8'hFF, "R1 xor reset state", state, 8'hFF);
        chk(period_done == 0, "R1 reset done", period_done, 0);
        chk(lock_up == 0, "R7 no lock after reset", lock_up, 0);
        chk(s_state == 3'b111, "R1 w3 reset state", s_state, 3'b111);
        step_en = 1; tick(); step_en = 0;
        chk(state == m_xor(8'hFF, 7'h38), "R1 default coefficients", state,
            m_xor(8'hFF, 7'h38));
        do_reset(1'b1);
        chk(state == 8'h00, "R1 xnor reset state", state, 8'h00);
        chk(lock_up == 0, "R1 xnor reset not forbidden", lock_up, 0);
    endtask

    task automatic t_w3_example();
        logic [7:0] seen;
        bit         bad;
        seen = '0; bad = 0;
        s_coef = 2'b01; s_coef_ld = 1; tick(); s_coef_ld = 0;
        s_seed = 3'b111; s_seed_ld = 1; tick(); s_seed_ld = 0;
        chk(s_done == 0, "R8 no pulse on load", s_done, 0);
        s_step = 1;
        tick();
        chk(s_state == 3'b101, "R3 first step", s_state, 3'b101);
        tick();
        chk(s_state == 3'b001, "R3 second step", s_state, 3'b001);
        seen[7] = 1; seen[5] = 1; seen[1] = 1;
        for (int k = 3; k <= 7; k++) begin
            tick();
            if (k < 7) begin
                if (seen[s_state] || s_state == 0 || s_done) bad = 1;
                seen[s_state] = 1;
            end
        end
        s_step = 0;
        chk(!bad, "R3 seven distinct nonzero states", seen, 8'hFE);
        chk(seen == 8'hFE, "R3 state set", seen, 8'hFE);
        chk(s_state == 3'b111 && s_done, "R8 w3 pulse at return",
            {s_done, s_state}, 4'hF);
        tick();
        chk(s_done == 0, "R8 pulse one cycle", s_done, 0);
    endtask

    task automatic t_xor_steps();
        logic [W-1:0] exp;
        bit           bad;
        bad = 0;
        mode_xnor = 0;
        load_coef(7'h55);
        load_seed(8'hA3);
        exp = 8'hA3;
        step_en = 1;
        for (int k = 0; k < 20; k++) begin
            exp = m_xor(exp, 7'h55);
            tick();
            if (state !== exp) bad = 1;
        end
        step_en = 0;
        chk(!bad, "R2 xor sequence taps 55", state, exp);
    endtask

    task automatic t_hold_and_seed();
        logic [W-1:0] keep;
        keep = state;
        for (int k = 0; k < 4; k++) tick();
        chk(state == keep, "R5 hold when disabled", state, keep);
        seed_val = 8'h3C; seed_ld = 1; step_en = 1; tick();
        seed_ld = 0; step_en = 0;
        chk(state == 8'h3C, "R6 seed overrides step", state, 8'h3C);
        seed_val = 8'h81; seed_ld = 1; tick(); seed_ld = 0;
        chk(state == 8'h81, "R6 seed without enable", state, 8'h81);
    endtask

    task automatic t_coef_timing();
        logic [W-1:0] exp;
        load_coef(7'h38);
        load_seed(8'h5A);
        coef_val = 7'h03; coef_ld = 1; tick(); coef_ld = 0;
        chk(state == 8'h5A, "R9 coef load leaves state", state, 8'h5A);
        coef_val = 7'h11; coef_ld = 1; step_en = 1; tick(); coef_ld = 0;
        exp = m_xor(8'h5A, 7'h03);
        chk(state == exp, "R9 same-cycle step uses old taps", state, exp);
        tick(); step_en = 0;
        exp = m_xor(exp, 7'h11);
        chk(state == exp, "R9 next step uses new taps", state, exp);
    endtask

    task automatic t_xnor();
        logic [W-1:0] exp;
        bit           bad;
        bad = 0;
        mode_xnor = 1;
        load_coef(7'h38);
        load_seed(8'h12);
        exp = 8'h12;
        step_en = 1;
        for (int k = 0; k < 16; k++) begin
            exp = m_xnor(exp, 7'h38);
            tick();
            if (state !== exp || lock_up) bad = 1;
        end
        step_en = 0;
        chk(!bad, "R4 xnor sequence", state, exp);
        load_seed(8'hFF);
        chk(lock_up == 1, "R7 xnor forbidden seed flagged", lock_up, 1);
        step_en = 1; tick(); tick(); step_en = 0;
        chk(state == 8'hFF, "R7 xnor lock holds", state, 8'hFF);
        mode_xnor = 0; #1;
        chk(lock_up == 0, "R7 flag follows mode", lock_up, 0);
    endtask

    task automatic t_xor_lock();
        mode_xnor = 0;
        load_seed(8'h00);
        chk(lock_up == 1, "R7 xor forbidden seed flagged", lock_up, 1);
        step_en = 1; tick(); tick(); tick(); step_en = 0;
        chk(state == 8'h00, "R7 xor lock holds", state, 8'h00);
    endtask

    task automatic t_period();
        logic [W-1:0] exp;
        int           first_hit;
        bit           bad;
        bad = 0; first_hit = -1;
        mode_xnor = 0;
        load_coef(7'h38);
        load_seed(8'h01);
        chk(period_done == 0, "R8 no pulse after load", period_done, 0);
        exp = 8'h01;
        step_en = 1;
        for (int k = 1; k <= 256; k++) begin
            exp = m_xor(exp, 7'h38);
            tick();
            if (state !== exp || state == 0) bad = 1;
            if (period_done && first_hit < 0) first_hit = k;
            if (k == 256 && period_done) bad = 1;
        end
        step_en = 0;
        chk(!bad, "R10 sequence nonzero and matches", state, exp);
        chk(first_hit == 255, "R10 period 255", first_hit, 255);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  End of test - %0d assertions evaluated, %0d failures",
                 n_chk, n_fail);
        $finish;
    end

    initial begin
        seed_val = '0; coef_val = '0; s_seed = '0; s_coef = '0;
        t_reset();
        t_w3_example();
        t_xor_steps();
        t_hold_and_seed();
        t_coef_timing();
        t_xnor();
        t_xor_lock();
        t_period();
        $display("  End of test - %0d assertions evaluated, %0d failures",
                 n_chk, n_fail);
        $finish;
    end

endmodule